// File: doc/BRIEF.md
# GPIO Port Register Interface

This block is the register-side slave of an eight-pin general-purpose I/O port. A simple 32-bit bus reaches it with byte offsets. Through the bus, software sets which pins are outputs and what they drive, and sets the interrupt behaviour. It reads the raw and the masked interrupt status and clears pending bits by writing ones. It also reads a fixed table of eight identification bytes. Pin output values and output enables leave the block directly. The configuration for an external edge/level detection unit leaves it as well. That unit reports newly detected events back as one-cycle set pulses.

The data register is reached through a 256-word window at the bottom of the map. The word address of each access forms a per-pin mask. Because of this, one pin can be driven or sampled without a read-modify-write sequence. Pins configured as inputs are sampled into the data register on every clock and cannot be written from the bus. Bus reads are registered: read data appears one clock after the read strobe and holds until the next read.

Top module: `gpio_regif`

## Requirements
- R1: After reset every register (data, direction, sense, both-edges, event, mask, mode select, raw status) is zero, and `bus_rdata`, `pin_oe` and `irq_out` are zero.
- R2: A write to any byte offset below 0x400 updates only those data bits whose mask bit (offset bits [9:2], mask bit i at offset bit i+2) is 1 and whose pin is an output. All other data bits keep their value.
- R3: A read of any offset below 0x400 returns the data register ANDed with the offset-derived mask. For an input pin, the data bit holds the `pin_in` value sampled at the previous rising clock edge.
- R4: Offsets 0x400 (direction), 0x404 (sense), 0x408 (both-edges), 0x40C (event), 0x410 (mask) and 0x420 (mode select) store bits [7:0] of a write. They read back zero-extended.
- R5: `pin_oe` equals the direction register, where 1 means output. `pin_out` equals the data register. `det_sense`, `det_both`, `det_event` and `alt_sel` equal their configuration registers.
- R6: A 1 on `det_set[i]` sets raw status bit i at the next edge. Raw status reads at 0x414. A set pulse wins over a clear of the same bit in the same cycle.
- R7: Offset 0x418 reads raw status ANDed with the mask register. `irq_out` is 1 exactly when that value is non-zero.
- R8: A write to 0x41C clears every raw status bit where the written value has a 1 and leaves the rest. A read of 0x41C returns zero.
- R9: A read of 0xFE0 + 4k (k = 0..7) returns byte k of the list 0x61, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to that range change nothing.
- R10: Reads of any other offset return zero. Writes to any other offset, including the read-only status offsets 0x414 and 0x418, change no register.
- R11: `bus_rdata` is loaded at the rising edge where `bus_rd` is 1 and keeps its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Data register driven toward the pads |
| pin_oe | output | 8 | Per-pin output enable |
| det_sense | output | 8 | Level (1) or edge (0) detection per pin |
| det_both | output | 8 | Detect both edges per pin |
| det_event | output | 8 | Rising/high (1) or falling/low (0) selection per pin |
| alt_sel | output | 8 | Alternate-function select per pin |
| det_set | input | 8 | One-cycle event pulses from the detection unit |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
A corrupted data bit shows on `pin_out` in the clock after the faulty write. A direction bit that is wrong shows on `pin_oe` at once, and through input sampling it changes what a masked data read returns. A raw status bit that is set or cleared wrongly appears on `irq_out` in the same cycle when it is unmasked. Otherwise it appears on the next read of 0x414. Because of this, the bench compares every output to its model on every clock, and it uses directed reads to bring out the state that no output shows.

// File: rtl/gpio_regif_pkg.sv
package gpio_regif_pkg;

   // Register selects produced by the address decoder.
   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_DIR,
      SEL_SENSE,
      SEL_BOTH,
      SEL_EVENT,
      SEL_MASK,
      SEL_RAW,
      SEL_MIS,
      SEL_CLR,
      SEL_ALT,
      SEL_ID
   } sel_e;

   // Word indices (byte offset >> 2) of the fixed registers.
   localparam logic [9:0] W_DIR   = 10'h100;
   localparam logic [9:0] W_SENSE = 10'h101;
   localparam logic [9:0] W_BOTH  = 10'h102;
   localparam logic [9:0] W_EVENT = 10'h103;
   localparam logic [9:0] W_MASK  = 10'h104;
   localparam logic [9:0] W_RAW   = 10'h105;
   localparam logic [9:0] W_MIS   = 10'h106;
   localparam logic [9:0] W_CLR   = 10'h107;
   localparam logic [9:0] W_ALT   = 10'h108;
   localparam logic [9:0] W_ID_LO = 10'h3F8;

   // Configuration register slots held in the top level array.
   localparam int CFG_DIR   = 0;
   localparam int CFG_SENSE = 1;
   localparam int CFG_BOTH  = 2;
   localparam int CFG_EVENT = 3;
   localparam int CFG_MASK  = 4;
   localparam int CFG_ALT   = 5;
   localparam int NCFG      = 6;

   function automatic sel_e cfg_sel(input int slot);
      case (slot)
         CFG_DIR:   return SEL_DIR;
         CFG_SENSE: return SEL_SENSE;
         CFG_BOTH:  return SEL_BOTH;
         CFG_EVENT: return SEL_EVENT;
         CFG_MASK:  return SEL_MASK;
         default:   return SEL_ALT;
      endcase
   endfunction

   // Identification bytes, one per word of the top page.
   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      case (idx)
         3'd0:    return 8'h61;
         3'd1:    return 8'h10;
         3'd2:    return 8'h14;
         3'd3:    return 8'h00;
         3'd4:    return 8'h0D;
         3'd5:    return 8'hF0;
         3'd6:    return 8'h05;
         default: return 8'hB1;
      endcase
   endfunction

endpackage

// File: rtl/gpio_regif_dec.sv
module gpio_regif_dec
   import gpio_regif_pkg::*;
#(
   parameter int AW    = 12,
   parameter int NPINS = 8
) (
   input  logic [AW-1:0]    addr,
   output sel_e             sel,
   output logic [NPINS-1:0] bitmask,
   output logic [2:0]       id_idx
);

   logic       in_page;
   logic [9:0] word;

   // Variant: a wider bus must have its upper address bits clear to hit the page.
   generate
      if (AW > 12) begin : g_wide
         assign in_page = ~|addr[AW-1:12];
      end else begin : g_exact
         assign in_page = 1'b1;
      end
   endgenerate

   assign word    = addr[11:2];
   assign bitmask = addr[NPINS+1:2];
   assign id_idx  = word[2:0];

   wire unused_byte_lane = ^addr[1:0];

   always_comb begin
      sel = SEL_NONE;
      if (!in_page) begin
         sel = SEL_NONE;
      end else if (word < W_DIR) begin
         sel = SEL_DATA;
      end else if (word >= W_ID_LO) begin
         sel = SEL_ID;
      end else begin
         case (word)
            W_DIR:   sel = SEL_DIR;
            W_SENSE: sel = SEL_SENSE;
            W_BOTH:  sel = SEL_BOTH;
            W_EVENT: sel = SEL_EVENT;
            W_MASK:  sel = SEL_MASK;
            W_RAW:   sel = SEL_RAW;
            W_MIS:   sel = SEL_MIS;
            W_CLR:   sel = SEL_CLR;
            W_ALT:   sel = SEL_ALT;
            default: sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/gpio_regif_data.sv
module gpio_regif_data #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [NPINS-1:0] bitmask,
   input  logic [NPINS-1:0] wdata,
   input  logic [NPINS-1:0] dir,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] data_q
);

   logic [NPINS-1:0] wmask;
   assign wmask = wr ? bitmask : '0;

   // One flop per pin: outputs take masked bus writes, inputs sample the pad.
   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q[i] <= 1'b0;
            end else if (!dir[i]) begin
               data_q[i] <= pin_in[i];
            end else if (wmask[i]) begin
               data_q[i] <= wdata[i];
            end
         end
      end
   endgenerate

   // R2: an output bit may only change where the access mask selected it.
   a_r2_masked_write : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((data_q ^ $past(data_q)) & $past(dir) & ~$past(wmask)) == '0));

   // R3: input bits mirror the pad value of the previous edge.
   a_r3_input_sample : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((data_q & ~$past(dir)) == ($past(pin_in) & ~$past(dir))));

endmodule

// File: rtl/gpio_regif_irq.sv
module gpio_regif_irq #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] set,
   input  logic             clr_we,
   input  logic [NPINS-1:0] clr_val,
   output logic [NPINS-1:0] raw_q
);

   logic [NPINS-1:0] clr_bits;
   assign clr_bits = clr_we ? clr_val : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr_bits) | set;
      end
   end

   // R6: a set pulse always lands, even against a clear of the same bit.
   a_r6_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((raw_q & $past(set)) == $past(set)));

   // R8: cleared bits without a concurrent set are zero afterwards.
   a_r8_clear_ones : assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((raw_q & $past(clr_val) & ~$past(set)) == '0));

endmodule

// File: rtl/gpio_regif.sv
module gpio_regif
   import gpio_regif_pkg::*;
#(
   parameter int AW    = 12,
   parameter int DW    = 32,
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] det_sense,
   output logic [NPINS-1:0] det_both,
   output logic [NPINS-1:0] det_event,
   output logic [NPINS-1:0] alt_sel,
   input  logic [NPINS-1:0] det_set,
   output logic             irq_out
);

   localparam int IDW = 8;

   // Elaboration-time parameter checks.
   generate
      if (AW < 12) begin : g_bad_aw
         $error("gpio_regif: AW must cover a 4 KiB page");
      end
      if (NPINS < 1 || NPINS > 8) begin : g_bad_npins
         $error("gpio_regif: NPINS must be 1..8 for the offset mask");
      end
      if (DW < IDW) begin : g_bad_dw
         $error("gpio_regif: DW must hold an identification byte");
      end
   endgenerate

   sel_e                        sel;
   logic [NPINS-1:0]            bitmask;
   logic [2:0]                  id_idx;
   logic [NCFG-1:0][NPINS-1:0]  cfg_q;
   logic [NPINS-1:0]            data_q;
   logic [NPINS-1:0]            raw_q;
   logic [NPINS-1:0]            mis;
   logic [NPINS-1:0]            wbits;
   logic [DW-1:0]               rd_val;
   logic                        id_wr;

   assign wbits = bus_wdata[NPINS-1:0];
   wire unused_wdata_hi = ^bus_wdata[DW-1:NPINS];

   gpio_regif_dec #(.AW(AW), .NPINS(NPINS)) u_dec (
      .addr    (bus_addr),
      .sel     (sel),
      .bitmask (bitmask),
      .id_idx  (id_idx)
   );

   // Configuration registers, one slot each, written when their select hits.
   generate
      for (genvar k = 0; k < NCFG; k++) begin : g_cfg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cfg_q[k] <= '0;
            end else if (bus_wr && sel == cfg_sel(k)) begin
               cfg_q[k] <= wbits;
            end
         end
      end
   endgenerate

   gpio_regif_data #(.NPINS(NPINS)) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr && sel == SEL_DATA),
      .bitmask (bitmask),
      .wdata   (wbits),
      .dir     (cfg_q[CFG_DIR]),
      .pin_in  (pin_in),
      .data_q  (data_q)
   );

   gpio_regif_irq #(.NPINS(NPINS)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (det_set),
      .clr_we  (bus_wr && sel == SEL_CLR),
      .clr_val (wbits),
      .raw_q   (raw_q)
   );

   assign mis       = raw_q & cfg_q[CFG_MASK];
   assign irq_out   = |mis;
   assign pin_out   = data_q;
   assign pin_oe    = cfg_q[CFG_DIR];
   assign det_sense = cfg_q[CFG_SENSE];
   assign det_both  = cfg_q[CFG_BOTH];
   assign det_event = cfg_q[CFG_EVENT];
   assign alt_sel   = cfg_q[CFG_ALT];

   // Read multiplexer.
   always_comb begin
      rd_val = '0;
      case (sel)
         SEL_DATA:  rd_val[NPINS-1:0] = data_q & bitmask;
         SEL_DIR:   rd_val[NPINS-1:0] = cfg_q[CFG_DIR];
         SEL_SENSE: rd_val[NPINS-1:0] = cfg_q[CFG_SENSE];
         SEL_BOTH:  rd_val[NPINS-1:0] = cfg_q[CFG_BOTH];
         SEL_EVENT: rd_val[NPINS-1:0] = cfg_q[CFG_EVENT];
         SEL_MASK:  rd_val[NPINS-1:0] = cfg_q[CFG_MASK];
         SEL_ALT:   rd_val[NPINS-1:0] = cfg_q[CFG_ALT];
         SEL_RAW:   rd_val[NPINS-1:0] = raw_q;
         SEL_MIS:   rd_val[NPINS-1:0] = mis;
         SEL_ID:    rd_val[IDW-1:0]   = id_byte(id_idx);
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_val;
      end
   end

   assign id_wr = bus_wr && sel == SEL_ID;

   // R11: read data only moves on a read strobe.
   a_r11_rdata_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R4: a direction write lands its low byte on the output enables.
   a_r4_dir_write : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_DIR) |=> (pin_oe == $past(wbits)));

   // R9: writes into the identification page leave configuration untouched.
   a_r9_id_readonly : assert property (@(posedge clk) disable iff (!rst_n)
      id_wr |=> $stable(cfg_q));

endmodule

// File: tb/sim_gpio_regif.sv
module sim_gpio_regif;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = 8'h30;
   logic [7:0]  pin_out, pin_oe, det_sense, det_both, det_event, alt_sel;
   logic [7:0]  det_set = '0;
   logic        irq_out;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   bit live = 1'b0;

   always #5 clk = ~clk;

   gpio_regif u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .det_sense(det_sense), .det_both(det_both), .det_event(det_event),
      .alt_sel(alt_sel), .det_set(det_set), .irq_out(irq_out)
   );

   // ---------------- reference model ----------------
   int m_data, m_dir, m_sense, m_both, m_event, m_mask, m_alt, m_raw, m_rdata;
   int id_tab[8] = '{'h61, 'h10, 'h14, 'h00, 'h0D, 'hF0, 'h05, 'hB1};

   function automatic int model_read(input int a);
      if (a < 'h400)                 return m_data & ((a >> 2) & 'hFF);
      if (a >= 'hFE0 && a <= 'hFFF)  return id_tab[(a - 'hFE0) >> 2];
      case (a & 'hFFC)
         'h400: return m_dir;
         'h404: return m_sense;
         'h408: return m_both;
         'h40C: return m_event;
         'h410: return m_mask;
         'h414: return m_raw;
         'h418: return m_raw & m_mask;
         'h420: return m_alt;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_data = 0; m_dir = 0; m_sense = 0; m_both = 0; m_event = 0;
         m_mask = 0; m_alt = 0; m_raw = 0; m_rdata = 0;
      end else begin
         int a, w, nd, nr, msk;
         a  = int'(bus_addr);
         w  = int'(bus_wdata) & 'hFF;
         if (bus_rd) m_rdata = model_read(a);
         nd = (m_data & m_dir) | (int'(pin_in) & ~m_dir & 'hFF);
         nr = m_raw;
         if (bus_wr) begin
            if (a < 'h400) begin
               msk = (a >> 2) & 'hFF & m_dir;
               nd  = (nd & ~msk) | (w & msk);
            end else begin
               case (a & 'hFFC)
                  'h400: m_dir   = w;
                  'h404: m_sense = w;
                  'h408: m_both  = w;
                  'h40C: m_event = w;
                  'h410: m_mask  = w;
                  'h41C: nr      = nr & ~w;
                  'h420: m_alt   = w;
                  default: ;
               endcase
            end
         end
         nr = nr | int'(det_set);
         m_data = nd & 'hFF;
         m_raw  = nr & 'hFF;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Per-clock comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (live && rst_n) begin
         check("R11 rdata vs model", int'(bus_rdata), m_rdata);
         check("R5 pin_out vs model", int'(pin_out), m_data);
         check("R5 pin_oe vs model", int'(pin_oe), m_dir);
         check("R7 irq_out vs model", int'(irq_out), int'((m_raw & m_mask) != 0));
      end
   end

   task automatic bus_write(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a[11:0]; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int a, output int v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a[11:0];
      @(negedge clk);
      bus_rd = 1'b0;
      v = int'(bus_rdata);
   endtask

   task automatic read_check(input string tag, input int a, input int exp);
      int v;
      bus_read(a, v);
      check(tag, v, exp);
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      int v;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rdata after reset", int'(bus_rdata), 0);
      check("R1 pin_oe after reset", int'(pin_oe), 0);
      check("R1 irq_out after reset", int'(irq_out), 0);
      rst_n = 1'b1;
      live  = 1'b1;
      read_check("R1 direction reset", 'h400, 0);
      read_check("R1 raw status reset", 'h414, 0);

      // R4/R5: direction keeps low byte only
      bus_write('h400, 'hFFFF_FF0F);
      read_check("R4 direction readback", 'h400, 'h0F);
      check("R5 pin_oe follows direction", int'(pin_oe), 'h0F);

      // R2: masked data writes touch only selected output bits
      bus_write('h3FC, 'hA5);
      check("R2 full-mask write outputs", int'(pin_out) & 'h0F, 'h05);
      bus_write('h010, 'h00);
      check("R2 single-bit clear", int'(pin_out) & 'h0F, 'h01);
      bus_write('h008, 'hFF);
      bus_write('h008, 'h00);
      bus_write('h0C0, 'hFF);
      check("R2 input bits not writable", int'(pin_out) & 'hF0, 'h30);

      // R3: masked reads and sampled inputs
      read_check("R3 full-mask read", 'h3FC, 'h31);
      read_check("R3 mask 0x10 read", 'h040, 'h10);
      read_check("R3 mask 0x02 read", 'h008, 'h00);
      pin_in = 8'hC0;
      @(negedge clk);
      read_check("R3 new input sample", 'h3FD, 'hC1);

      // R4/R5: configuration registers
      bus_write('h404, 'h1122_3344);
      bus_write('h408, 'h5A);
      bus_write('h40C, 'hC3);
      bus_write('h420, 'h99);
      read_check("R4 sense readback", 'h404, 'h44);
      read_check("R4 both-edges readback", 'h408, 'h5A);
      read_check("R4 event readback", 'h40C, 'hC3);
      read_check("R4 mode readback", 'h420, 'h99);
      check("R5 det_sense", int'(det_sense), 'h44);
      check("R5 det_both", int'(det_both), 'h5A);
      check("R5 det_event", int'(det_event), 'hC3);
      check("R5 alt_sel", int'(alt_sel), 'h99);

      // R6/R7/R8: interrupt status
      @(negedge clk); det_set = 8'h81;
      @(negedge clk); det_set = 8'h00;
      read_check("R6 raw after set", 'h414, 'h81);
      check("R7 irq_out masked off", int'(irq_out), 0);
      bus_write('h410, 'h01);
      check("R7 irq_out unmasked", int'(irq_out), 1);
      read_check("R7 masked status", 'h418, 'h01);
      bus_write('h41C, 'h01);
      read_check("R8 raw after clear", 'h414, 'h80);
      check("R8 irq_out after clear", int'(irq_out), 0);
      read_check("R8 clear offset reads zero", 'h41C, 0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'h41C; bus_wdata = 'h80; det_set = 8'h80;
      @(negedge clk);
      bus_wr = 1'b0; det_set = 8'h00;
      read_check("R6 set beats clear", 'h414, 'h80);

      // R9: identification page
      for (int k = 0; k < 8; k++) read_check("R9 id byte", 'hFE0 + 4 * k, id_tab[k]);
      bus_write('hFE0, 'h0);
      bus_write('hFE4, 'hFF);
      read_check("R9 id after write", 'hFE0, 'h61);
      read_check("R9 config after id write", 'h400, 'h0F);

      // R10: reserved and read-only offsets
      read_check("R10 reserved 0x424", 'h424, 0);
      read_check("R10 reserved 0x800", 'h800, 0);
      bus_write('h424, 'hFF);
      bus_write('h414, 'hFF);
      bus_write('h418, 'h00);
      bus_write('h800, 'hFF);
      read_check("R10 raw unchanged", 'h414, 'h80);
      read_check("R10 mask unchanged", 'h410, 'h01);
      read_check("R10 direction unchanged", 'h400, 'h0F);

      // R11: held read data
      read_check("R11 last id byte", 'hFFC, 'hB1);
      det_set = 8'h02;
      @(negedge clk); det_set = 8'h00;
      repeat (3) @(negedge clk);
      check("R11 rdata held", int'(bus_rdata), 'hB1);

      done = 1'b1;
      live = 1'b0;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
      end
   end

endmodule